// File: doc/BRIEF.md
# Shared-MAC Five-Tap Horizontal YUV Filter

This block filters one video line of planar luma and chroma samples in the horizontal direction. A single five-tap multiply-accumulate pipeline serves all three components: a slot sequencer chooses the component for each cycle and feeds a window of five samples from the matching line store into the pipeline. Luma uses one coefficient set and both chroma components share a second set.

Chroma is either kept at half horizontal density (4:2:2 output, two slots per pixel) or doubled to full density before filtering (4:4:4 output, three slots per pixel). The packer collects the filtered components of each pixel into one 24-bit word and writes it into a 16-entry output queue. The consumer drains the queue through a valid/ready handshake. When the queue is full, the sequencer and every pipeline stage hold their state until a slot frees up, so no word is lost.

Software loads a line through the write port, holds the coefficients steady, selects the chroma mode and pulses the start input.

Top module: `yuv_hfilt5`

## Requirements
- R1: After a synchronous reset, `busy` and `out_valid` are low.
- R2: Coefficient t (t = 0..4, bits t*10+9 down to t*10 of the coefficient bus) is a signed two's complement value with 8 fractional bits. It multiplies the sample at offset t-2 from the current position. The five products are summed, 128 is added, the sum is shifted arithmetically right by 8 and clamped to 0..255. Luma uses `coef_y` and chroma uses `coef_c`.
- R3: A tap position before the first sample or after the last sample of the line being filtered takes the value of the nearest end sample.
- R4: In 4:2:2 mode (`mode_444` = 0 when started), the word for pixel x is bits 23:16 = 0, bits 15:8 = filtered Y(x), and bits 7:0 = filtered U(x/2) for even x or filtered V(x/2) for odd x. Chroma is filtered over its own half-length line.
- R5: In 4:4:4 mode, the word for pixel x is bits 23:16 = Y, 15:8 = U, 7:0 = V. Chroma is filtered over a full-length line in which even position 2k holds c[k] and odd position 2k+1 holds (c[k] + c[k+1] + 1) >> 1, with c[k+1] replaced by c[k] at the last chroma sample.
- R6: Each start yields exactly LINE_W words, one per pixel, in ascending pixel order.
- R7: Output uses a valid/ready handshake through a 16-word queue. While the queue is full, the sequencer and the pipeline hold their state, and no word is dropped or repeated.
- R8: A start pulse while `busy` is high is ignored, including the mode value that comes with it.
- R9: When the queue never fills, `busy` stays high for exactly 2*LINE_W cycles in 4:2:2 mode and 3*LINE_W cycles in 4:4:4 mode.
- R10: Line samples are written through `wr_en`/`wr_comp`/`wr_addr`/`wr_data`, with `wr_comp` 0 = Y, 1 = U, 2 = V. Chroma occupies addresses 0..LINE_W/2-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Line store write strobe |
| wr_comp | input | 2 | Component selector for the write (0 Y, 1 U, 2 V) |
| wr_addr | input | $clog2(LINE_W) | Sample address within the line |
| wr_data | input | 8 | Sample value |
| coef_y | input | 50 | Luma coefficients, five signed 10-bit fields |
| coef_c | input | 50 | Chroma coefficients, five signed 10-bit fields |
| mode_444 | input | 1 | 1 selects 4:4:4 output, 0 selects 4:2:2; sampled at start |
| start | input | 1 | Begins filtering the stored line |
| busy | output | 1 | High while the sequencer issues slots |
| out_valid | output | 1 | Output queue holds a word |
| out_ready | input | 1 | Consumer accepts the word at the clock edge |
| out_data | output | 24 | Packed pixel word |

## Verification
An identity kernel on random samples checks component sequencing and packing without arithmetic in the way. A smoothing kernel on a ramp makes end replication visible, because replicated ends differ from extrapolated ones. A sharpening kernel on full-scale binary samples drives the accumulator past both clamp limits. Random kernels with random consumer throttling, and a long period with ready held low, separate a correct freeze from dropped or duplicated words. A start pulse in mid-line with the opposite mode would show up as extra or mispacked words. Slot counts with an always-ready consumer show whether the two modes take two or three cycles per pixel.

// File: rtl/hf5_pkg.sv
package hf5_pkg;
    localparam int NTAP  = 5;
    localparam int DW    = 8;
    localparam int CW    = 10;
    localparam int FRAC  = 8;
    localparam int PW    = DW + 1 + CW;
    localparam int ACC_W = PW + 3;
    localparam int OW    = 3 * DW;

    typedef enum logic [1:0] {
        COMP_Y = 2'd0,
        COMP_U = 2'd1,
        COMP_V = 2'd2
    } comp_e;

    typedef struct packed {
        logic  vld;
        comp_e comp;
        logic  m444;
        logic  last_pix;
    } hf_tag_t;

    function automatic int clampi(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic logic [DW-1:0] round_sat(input logic signed [ACC_W-1:0] s);
        logic signed [ACC_W-1:0] rnd_k, max_k, r;
        rnd_k = ACC_W'(1 << (FRAC - 1));
        max_k = ACC_W'((1 << DW) - 1);
        r = (s + rnd_k) >>> FRAC;
        if (r < 0)          return '0;
        else if (r > max_k) return '1;
        else                return r[DW-1:0];
    endfunction
endpackage

// File: rtl/hf5_seq.sv
module hf5_seq import hf5_pkg::*; #(
    parameter int LINE_W = 32,
    localparam int XW = $clog2(LINE_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          start,
    input  logic          mode_444,
    output logic          busy,
    output hf_tag_t       tag_o,
    output logic [XW-1:0] pos_o
);
    logic [XW-1:0] x;
    logic [1:0]    slot;
    logic          mode_q;
    logic          last_slot;

    always_comb begin
        last_slot    = mode_q ? (slot == 2'd2) : (slot == 2'd1);
        tag_o        = '0;
        tag_o.vld    = busy;
        tag_o.m444   = mode_q;
        tag_o.last_pix = last_slot;
        pos_o        = x;
        if (slot == 2'd0) begin
            tag_o.comp = COMP_Y;
        end else if (mode_q) begin
            tag_o.comp = (slot == 2'd1) ? COMP_U : COMP_V;
        end else begin
            tag_o.comp = x[0] ? COMP_V : COMP_U;
            pos_o      = x >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            x      <= '0;
            slot   <= '0;
            mode_q <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                x      <= '0;
                slot   <= '0;
                mode_q <= mode_444;
            end
        end else if (adv) begin
            if (last_slot) begin
                slot <= '0;
                if (x == XW'(LINE_W - 1)) busy <= 1'b0;
                else                      x    <= x + 1'b1;
            end else begin
                slot <= slot + 1'b1;
            end
        end
    end

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !adv) |=> (busy && $stable(x) && $stable(slot)));
    p_slot_range_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (slot <= (mode_q ? 2'd2 : 2'd1)));
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(mode_q));
endmodule

// File: rtl/hf5_taps.sv
module hf5_taps import hf5_pkg::*; #(
    parameter int LINE_W = 32,
    localparam int XW  = $clog2(LINE_W),
    localparam int HW  = LINE_W / 2,
    localparam int HXW = $clog2(HW)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     adv,
    input  logic                     wr_en,
    input  logic [1:0]               wr_comp,
    input  logic [XW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  hf_tag_t                  tag_i,
    input  logic [XW-1:0]            pos_i,
    output hf_tag_t                  tag_o,
    output logic [NTAP-1:0][DW-1:0]  taps_o
);
    logic [DW-1:0] ybuf [LINE_W];
    logic [DW-1:0] ubuf [HW];
    logic [DW-1:0] vbuf [HW];
    logic [NTAP-1:0][DW-1:0] taps_c;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            case (wr_comp)
                2'd0: ybuf[wr_addr] <= wr_data;
                2'd1: if (wr_addr < XW'(HW)) ubuf[wr_addr[HXW-1:0]] <= wr_data;
                2'd2: if (wr_addr < XW'(HW)) vbuf[wr_addr[HXW-1:0]] <= wr_data;
                default: ;
            endcase
        end
    end

    // Sample at position p of the line seen by component c; in 4:4:4 mode the
    // chroma line is doubled, odd positions averaging two stored neighbours.
    function automatic logic [DW-1:0] fetch(input int p, input comp_e c, input logic m444);
        int k, k1, q;
        logic [DW-1:0] a, b;
        if (c == COMP_Y) begin
            q = clampi(p, 0, LINE_W - 1);
            return ybuf[XW'(q)];
        end
        if (!m444) begin
            k  = clampi(p, 0, HW - 1);
            k1 = k;
        end else begin
            q  = clampi(p, 0, LINE_W - 1);
            k  = q / 2;
            k1 = (q % 2 == 1) ? clampi(k + 1, 0, HW - 1) : k;
        end
        a = (c == COMP_U) ? ubuf[HXW'(k)]  : vbuf[HXW'(k)];
        b = (c == COMP_U) ? ubuf[HXW'(k1)] : vbuf[HXW'(k1)];
        return DW'(({1'b0, a} + {1'b0, b} + 9'd1) >> 1);
    endfunction

    always_comb begin
        for (int t = 0; t < NTAP; t++) begin
            taps_c[t] = fetch(int'(pos_i) + t - NTAP / 2, tag_i.comp, tag_i.m444);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_o  <= '0;
            taps_o <= '0;
        end else if (adv) begin
            tag_o  <= tag_i;
            taps_o <= taps_c;
        end
    end
endmodule

// File: rtl/hf5_mac.sv
module hf5_mac import hf5_pkg::*; (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     adv,
    input  hf_tag_t                  tag_i,
    input  logic [NTAP-1:0][DW-1:0]  taps_i,
    input  logic [NTAP*CW-1:0]       coef_y,
    input  logic [NTAP*CW-1:0]       coef_c,
    output hf_tag_t                  tag_o,
    output logic [DW-1:0]            res_o
);
    logic signed [PW-1:0]    prod_c [NTAP];
    logic signed [PW-1:0]    prod_q [NTAP];
    logic signed [ACC_W-1:0] pa_q, pb_q, pc_q, sum_q;
    hf_tag_t                 t2, t3, t4;

    for (genvar g = 0; g < NTAP; g++) begin : g_mul
        logic signed [CW-1:0] k;
        assign k = (tag_i.comp == COMP_Y) ? $signed(coef_y[g*CW +: CW])
                                          : $signed(coef_c[g*CW +: CW]);
        assign prod_c[g] = $signed({1'b0, taps_i[g]}) * k;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t2 <= '0; t3 <= '0; t4 <= '0; tag_o <= '0;
            for (int i = 0; i < NTAP; i++) prod_q[i] <= '0;
            pa_q <= '0; pb_q <= '0; pc_q <= '0; sum_q <= '0;
            res_o <= '0;
        end else if (adv) begin
            t2 <= tag_i;
            for (int i = 0; i < NTAP; i++) prod_q[i] <= prod_c[i];
            t3   <= t2;
            pa_q <= ACC_W'(prod_q[0]) + ACC_W'(prod_q[1]);
            pb_q <= ACC_W'(prod_q[2]) + ACC_W'(prod_q[3]);
            pc_q <= ACC_W'(prod_q[4]);
            t4    <= t3;
            sum_q <= pa_q + pb_q + pc_q;
            tag_o <= t4;
            res_o <= round_sat(sum_q);
        end
    end

    p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(res_o) && $stable(tag_o)));
endmodule

// File: rtl/hf5_ofifo.sv
module hf5_ofifo #(
    parameter int DEPTH = 16,
    parameter int WW    = 24,
    localparam int AW   = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [WW-1:0] din,
    output logic          full,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [WW-1:0] out_data
);
    logic [WW-1:0]   mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic [CNTW-1:0] cnt;
    logic            do_push, do_pop;

    assign full      = (cnt == CNTW'(DEPTH));
    assign out_valid = (cnt != '0);
    assign out_data  = mem[rp];
    assign do_push   = push && !full;
    assign do_pop    = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0; rp <= '0; cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CNTW'(do_push) - CNTW'(do_pop);
        end
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    p_word_visible_r6: assert property (@(posedge clk) disable iff (rst)
        do_push |=> out_valid);
endmodule

// File: rtl/yuv_hfilt5.sv
module yuv_hfilt5 import hf5_pkg::*; #(
    parameter int LINE_W     = 32,
    parameter int FIFO_DEPTH = 16,
    localparam int XW = $clog2(LINE_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [1:0]         wr_comp,
    input  logic [XW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [NTAP*CW-1:0] coef_y,
    input  logic [NTAP*CW-1:0] coef_c,
    input  logic               mode_444,
    input  logic               start,
    output logic               busy,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [OW-1:0]      out_data
);
    logic                    adv, full, push;
    hf_tag_t                 seq_tag, s1_tag, s5_tag;
    logic [XW-1:0]           seq_pos;
    logic [NTAP-1:0][DW-1:0] s1_taps;
    logic [DW-1:0]           s5_res, y_hold, u_hold;
    logic [OW-1:0]           word;

    assign adv = !full;

    hf5_seq #(.LINE_W(LINE_W)) u_seq (
        .clk(clk), .rst(rst), .adv(adv), .start(start), .mode_444(mode_444),
        .busy(busy), .tag_o(seq_tag), .pos_o(seq_pos)
    );

    hf5_taps #(.LINE_W(LINE_W)) u_taps (
        .clk(clk), .rst(rst), .adv(adv),
        .wr_en(wr_en), .wr_comp(wr_comp), .wr_addr(wr_addr), .wr_data(wr_data),
        .tag_i(seq_tag), .pos_i(seq_pos), .tag_o(s1_tag), .taps_o(s1_taps)
    );

    hf5_mac u_mac (
        .clk(clk), .rst(rst), .adv(adv), .tag_i(s1_tag), .taps_i(s1_taps),
        .coef_y(coef_y), .coef_c(coef_c), .tag_o(s5_tag), .res_o(s5_res)
    );

    // Packer: hold earlier components of the pixel, emit on its final slot.
    always_ff @(posedge clk) begin
        if (rst) begin
            y_hold <= '0;
            u_hold <= '0;
        end else if (adv && s5_tag.vld) begin
            if (s5_tag.comp == COMP_Y) y_hold <= s5_res;
            if (s5_tag.comp == COMP_U) u_hold <= s5_res;
        end
    end

    assign push = adv && s5_tag.vld && s5_tag.last_pix;
    assign word = s5_tag.m444 ? {y_hold, u_hold, s5_res} : {{DW{1'b0}}, y_hold, s5_res};

    hf5_ofifo #(.DEPTH(FIFO_DEPTH), .WW(OW)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .din(word), .full(full),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
    );

    p_push_on_chroma_r4: assert property (@(posedge clk) disable iff (rst)
        push |-> (s5_tag.comp != COMP_Y));
endmodule

// File: tb/tb_yuv_hfilt5.sv
module tb_yuv_hfilt5;
    localparam int W  = 32;
    localparam int HW = W / 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_comp = '0;
    logic [4:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [49:0] coef_y = '0, coef_c = '0;
    logic        mode_444 = 1'b0, start = 1'b0;
    logic        busy, out_valid, out_ready = 1'b1;
    logic [23:0] out_data;

    yuv_hfilt5 #(.LINE_W(W), .FIFO_DEPTH(16)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_comp(wr_comp), .wr_addr(wr_addr),
        .wr_data(wr_data), .coef_y(coef_y), .coef_c(coef_c), .mode_444(mode_444),
        .start(start), .busy(busy), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    always #4 clk = ~clk;

    int ly[W], lu[HW], lv[HW];
    int cy[5], cc[5];
    logic [23:0] exp_q[$];
    string       tag_q[$];
    int n_run = 0, n_fail = 0;
    int thr = 0;
    int busy_cnt = 0;
    bit counting = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int clampb(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic int src(input int comp, input bit m444, input int p);
        int k, q, a, b;
        if (comp == 0) return ly[clampb(p, 0, W - 1)];
        if (!m444) begin
            k = clampb(p, 0, HW - 1);
            return (comp == 1) ? lu[k] : lv[k];
        end
        q = clampb(p, 0, W - 1);
        k = q / 2;
        a = (comp == 1) ? lu[k] : lv[k];
        if (q % 2 == 0) return a;
        b = (comp == 1) ? lu[clampb(k + 1, 0, HW - 1)] : lv[clampb(k + 1, 0, HW - 1)];
        return (a + b + 1) / 2;
    endfunction

    function automatic int model(input int comp, input bit m444, input int ctr);
        int acc = 0, r;
        for (int t = 0; t < 5; t++)
            acc += ((comp == 0) ? cy[t] : cc[t]) * src(comp, m444, ctr + t - 2);
        r = (acc + 128) >>> 8;
        return clampb(r, 0, 255);
    endfunction

    // Monitor: choose ready for the coming edge, then score the transfer.
    always @(negedge clk) begin
        logic [23:0] e;
        string       tg;
        if (thr == 0)      out_ready = 1'b1;
        else if (thr == 1) out_ready = ($urandom_range(1) == 1);
        else               out_ready = 1'b0;
        if (counting && busy) busy_cnt++;
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 R8", "unexpected extra word", out_data, 0);
            end else begin
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                check(out_data == e, tg, "pixel word", out_data, e);
            end
        end
    end

    task automatic set_coefs();
        for (int t = 0; t < 5; t++) begin
            coef_y[t*10 +: 10] = 10'(cy[t]);
            coef_c[t*10 +: 10] = 10'(cc[t]);
        end
    endtask

    task automatic wr(input int comp, input int addr, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_comp = 2'(comp); wr_addr = 5'(addr); wr_data = 8'(val);
    endtask

    // kind 0 random, 1 luma ramp with random chroma, 2 full-scale binary
    task automatic load(input int kind);
        for (int x = 0; x < W; x++)
            ly[x] = (kind == 1) ? x * 8 : (kind == 2 ? 255 * $urandom_range(1) : $urandom_range(255));
        for (int k = 0; k < HW; k++) begin
            lu[k] = (kind == 2) ? 255 * $urandom_range(1) : $urandom_range(255);
            lv[k] = (kind == 2) ? 255 * $urandom_range(1) : $urandom_range(255);
        end
        for (int x = 0; x < W; x++)  wr(0, x, ly[x]);
        for (int k = 0; k < HW; k++) begin wr(1, k, lu[k]); wr(2, k, lv[k]); end
        @(negedge clk);
        wr_en = 1'b0;
        set_coefs();
    endtask

    task automatic run_line(input bit m444, input int throttle, input bit poke,
                            input bit stall, input string tg, output int cyc);
        int y, u, v, c;
        for (int x = 0; x < W; x++) begin
            y = model(0, m444, x);
            if (m444) begin
                u = model(1, 1'b1, x);
                v = model(2, 1'b1, x);
                exp_q.push_back({8'(y), 8'(u), 8'(v)});
            end else begin
                c = (x % 2 == 0) ? model(1, 1'b0, x / 2) : model(2, 1'b0, x / 2);
                exp_q.push_back({8'h00, 8'(y), 8'(c)});
            end
            tag_q.push_back(tg);
        end
        thr = stall ? 2 : throttle;
        busy_cnt = 0;
        counting = 1'b1;
        @(negedge clk); mode_444 = m444; start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (10) @(negedge clk);
            mode_444 = ~m444; start = 1'b1;
            @(negedge clk); start = 1'b0; mode_444 = m444;
        end
        if (stall) begin
            repeat (200) @(negedge clk);
            check(busy == 1'b1, "R7", "busy held while queue full", busy, 1);
            check(out_valid == 1'b1, "R7", "queue holds words while stalled", out_valid, 1);
            check(exp_q.size() == W, "R7", "no word leaves while ready low", exp_q.size(), W);
            thr = 1;
        end
        while (exp_q.size() != 0) @(negedge clk);
        while (busy) @(negedge clk);
        counting = 1'b0;
        cyc = busy_cnt;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

        // identity kernel, 4:2:2, consumer always ready
        cy = '{0, 0, 256, 0, 0}; cc = '{0, 0, 256, 0, 0};
        load(0);
        run_line(1'b0, 0, 1'b0, 1'b0, "R2 R4 R6 R10", cyc);
        check(cyc == 2 * W, "R9", "4:2:2 busy cycles", cyc, 2 * W);

        // smoothing on a ramp: end replication visible, 4:4:4
        cy = '{16, 64, 96, 64, 16}; cc = '{40, -30, 300, -30, -24};
        load(1);
        run_line(1'b1, 0, 1'b0, 1'b0, "R2 R3 R5 R6", cyc);
        check(cyc == 3 * W, "R9", "4:4:4 busy cycles", cyc, 3 * W);

        // sharpening on full-scale data: both clamp limits, throttled
        cy = '{-60, -120, 511, -120, -60}; cc = '{30, -40, 300, -20, -14};
        load(2);
        run_line(1'b0, 1, 1'b0, 1'b0, "R2 R3 R4 R7", cyc);

        // random kernels, 4:4:4, throttled
        for (int t = 0; t < 5; t++) begin
            cy[t] = int'($urandom_range(1023)) - 512;
            cc[t] = int'($urandom_range(1023)) - 512;
        end
        load(0);
        run_line(1'b1, 1, 1'b0, 1'b0, "R2 R3 R5 R7", cyc);

        // start pulse in mid-line must be ignored
        cy = '{-20, 50, 200, 40, -14}; cc = '{10, 60, 120, 60, 6};
        load(0);
        run_line(1'b0, 1, 1'b1, 1'b0, "R4 R6 R8", cyc);
        repeat (40) @(negedge clk);
        check(busy == 1'b0, "R8", "no second line after ignored start", busy, 0);
        check(out_valid == 1'b0, "R8", "no extra words after ignored start", out_valid, 0);

        // long backpressure: freeze, then drain in order
        load(0);
        run_line(1'b1, 1, 1'b0, 1'b1, "R5 R6 R7", cyc);

        check(exp_q.size() == 0, "R6", "all expected words seen", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule